// File: doc/BRIEF.md
# SDRAM burst column address generator

This block walks through the column addresses of one SDRAM burst in the order the memory array visits them. A start pulse supplies a starting column together with the burst settings: a length code and an ordering bit. From the next clock on, the block presents one column address per cycle, marks each valid beat, and flags the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside a block of columns aligned to the burst length. In sequential order the address counts upward and wraps within that block. In interleaved order each beat XORs the beat index into the low bits of the starting column.

Full-page bursts count upward through the whole row, wrapping at the top, until a stop or a new start ends them. A stop input ends any burst early. A new start takes effect on any clock, even in the middle of a burst. The column width is a parameter: 10 for a byte-wide organisation, 9 for a 16-bit one.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no start, `beat_valid` and `last_beat` are low.
- R2: When `start` is high at a rising edge, the next cycle shows `beat_valid` high and `col_out` equal to the sampled `start_col`. Further beats follow on consecutive cycles.
- R3: The length code `len_sel` selects the burst length L. Codes 0, 1, 2 and 3 give L = 1, 2, 4 and 8. Any code with bit 2 set selects full page. With `ilv` = 0 and a fixed length, beat k (counted from 0) has `col_out` equal to the start column with its low log2(L) bits replaced by (start + k) mod L.
- R4: With `ilv` = 1 and L of 2, 4 or 8, beat k has the low log2(L) bits of the start column XORed with k, and the upper bits unchanged. `ilv` has no effect on L = 1 or on full page.
- R5: A fixed burst gives exactly L valid beats. `last_beat` is high on the final beat only, and `beat_valid` is low on the cycle after it unless a start arrived.
- R6: In full-page mode beat k shows (start + k) mod 2^COL_W. `last_beat` stays low, and beats continue until a stop or a start.
- R7: A stop sampled at a rising edge while a beat is shown ends the burst, so `beat_valid` is low in the next cycle. A stop while idle has no effect. When start and stop are both high, start takes precedence.
- R8: A start during a burst restarts it at the new column, with the new length and ordering, in the next cycle.
- R9: Length and ordering are captured at start. Changing `len_sel` or `ilv` during a burst does not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W | Starting column address |
| len_sel | input | 3 | Length code: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| ilv | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop | input | 1 | End the current burst early |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
Every output is produced from state registered at the rising edge. The first beat therefore appears exactly one cycle after the edge that samples a start, and a stop or a final beat clears `beat_valid` exactly one cycle later. The bench updates a behavioural model on the same rising edge that the design uses, from the inputs it sampled. It compares `beat_valid`, `last_beat` and, on valid beats, `col_out` at every falling edge, so each result is checked in the cycle it is due. Stimulus changes only at falling edges, after that cycle's comparison.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             last_beat
);

  logic             active_q, ilv_q, fp_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] sel_mask, offs;

  always_comb begin
    sel_mask = '1;
    if (!len_sel[2]) begin
      case (len_sel[1:0])
        2'd0: sel_mask = COL_W'(0);
        2'd1: sel_mask = COL_W'(1);
        2'd2: sel_mask = COL_W'(3);
        default: sel_mask = COL_W'(7);
      endcase
    end
  end

  assign offs       = (ilv_q && !fp_q) ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col_out    = (base_q & ~mask_q) | (offs & mask_q);
  assign beat_valid = active_q;
  assign last_beat  = active_q && !fp_q && (cnt_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ilv_q    <= 1'b0;
      fp_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      ilv_q    <= ilv;
      fp_q     <= len_sel[2];
      base_q   <= start_col;
      cnt_q    <= '0;
      mask_q   <= sel_mask;
    end else if (active_q) begin
      if (stop || last_beat) active_q <= 1'b0;
      else                   cnt_q    <= cnt_q + 1'b1;
    end
  end

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col_out == $past(start_col)));

  p_end_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);

  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !beat_valid);

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && fp_q && !stop && !start) |=>
      (beat_valid && col_out == COL_W'($past(col_out) + 1'b1)));

  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && fp_q) |-> !last_beat);

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  localparam int COL_W = 10;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ilv = 1'b0, stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] len_sel = 3'd0;
  logic [COL_W-1:0] col_out;
  logic beat_valid, last_beat;

  sdram_burst_colgen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_sel(len_sel), .ilv(ilv), .stop(stop),
    .col_out(col_out), .beat_valid(beat_valid), .last_beat(last_beat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R1";
  int m_active = 0, m_k = 0, m_base = 0, m_len = 1, m_ilv = 0, m_fp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_k = 0;
    end else if (start) begin
      m_active = 1; m_k = 0; m_base = int'(start_col);
      m_fp = int'(len_sel[2]); m_ilv = int'(ilv);
      m_len = len_sel[2] ? PAGE : (1 << len_sel[1:0]);
    end else if (m_active != 0) begin
      if (stop) m_active = 0;
      else if (m_fp == 0 && m_k == m_len - 1) m_active = 0;
      else m_k = (m_k + 1) % PAGE;
    end
  end

  function automatic int exp_col();
    int blk, low;
    if (m_fp != 0) return (m_base + m_k) % PAGE;
    blk = m_base - (m_base % m_len);
    low = m_base % m_len;
    if (m_ilv != 0) return blk + (low ^ m_k);
    return blk + ((low + m_k) % m_len);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s phase %s: actual %0d expected %0d", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string t;
    cycles++;
    t = (m_active == 0) ? "R7" : (m_fp != 0) ? "R6" : (m_ilv != 0) ? "R4" : "R3";
    check(rst_n ? t : "R1", int'(beat_valid), m_active);
    check("R5", int'(last_beat), (m_active != 0 && m_fp == 0 && m_k == m_len - 1) ? 1 : 0);
    if (m_active != 0) check(t, int'(col_out), exp_col());
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic go(int col, int code, bit il);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(col); len_sel = 3'(code); ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R3 R4 R5: every fixed length, both orderings, several start columns
    phase = "R3R4R5";
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++) begin
        go(13, code, il[0]); idle(9);
        go(1022, code, il[0]); idle(9);
        go(6, code, il[0]); idle(9);
      end
    // R6: full page wraps past the top of the row, then R7 stop
    phase = "R6";
    go(1019, 4, 1'b1); idle(12);
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0; idle(3);
    // R7: stop mid fixed burst, stop while idle, start beats stop
    phase = "R7";
    go(40, 3, 1'b0); stop = 1'b1; @(negedge clk); stop = 1'b0; idle(4);
    stop = 1'b1; idle(2); stop = 1'b0; idle(2);
    @(negedge clk); start = 1'b1; stop = 1'b1; start_col = 10'd77; len_sel = 3'd2; ilv = 1'b0;
    @(negedge clk); start = 1'b0; stop = 1'b0; idle(6);
    // R8: restart mid burst with new mode
    phase = "R8";
    go(100, 3, 1'b0); idle(2); go(205, 2, 1'b1); idle(6);
    go(3, 1, 1'b0); go(9, 3, 1'b1); go(500, 5, 1'b0); idle(4);
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0; idle(2);
    // R9: settings changed during burst are ignored
    phase = "R9";
    go(58, 3, 1'b1); len_sel = 3'd0; ilv = 1'b0; idle(10);
    // R2: back-to-back starts every cycle
    phase = "R2";
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); start = 1'b1; start_col = COL_W'(i * 37); len_sel = 3'(i % 4); ilv = i[0];
    end
    @(negedge clk); start = 1'b0; idle(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule